// File: doc/BRIEF.md
# Factory Bad-Block Table Scanner

After reset this block walks a NAND-style array one erase block at a time, starting at block 0 and ending at the last block. For each block it asks a command sequencer to read one marker byte from the block's first page and, when needed, the same byte from the second page. Factory-erased locations read back as FFh, so any other value marks the block as unusable. The verdict for each block goes into an on-chip bitmap, one bit per block, and a running count of usable blocks is kept.

When the walk is over, a done flag rises and stays high. A query port then reports whether any block is unusable. A flag also warns when fewer usable blocks were found than the minimum the array is rated for. Block 0 is always reported usable, whatever its marker holds. The read interface is a valid/ready request carrying page and column, answered later by a one-cycle response strobe with the byte.

Top module: `badblk_scanner`

## Requirements
- R1: Read requests go out in ascending block order starting at block 0. For block b they name page b*PAGES_PER_BLK (and page b*PAGES_PER_BLK+1 for the second read), always at column MARK_COL (default 256, the first spare byte).
- R2: A block other than block 0 is marked invalid if a returned marker byte differs from 8'hFF. If the first-page marker is not 8'hFF, the second page is not requested and the next block starts at once.
- R3: Block 0 is always recorded valid, even if either of its markers differs from 8'hFF.
- R4: `valid_count` is 0 after reset and increases by exactly one at the clock edge where a valid block's last response is taken. It never changes otherwise.
- R5: `scan_done` rises at the edge that takes the last block's final response and stays high until reset. No request is issued while it is high.
- R6: While `scan_done` is low, `q_ready` and `q_invalid` are 0. Once it is high, `q_ready` is 1 and `q_invalid` combinationally gives the recorded verdict for block `q_blk` (1 = invalid).
- R7: `low_valid` is 1 exactly when `scan_done` is high and `valid_count` is below MIN_VALID (default 502).
- R8: Synchronous active-high `rst` clears the bitmap, the count and the done flag, and restarts the walk from block 0, even in the middle of a scan.
- R9: A request held with `rd_req_ready` low keeps `rd_req_valid` high and its page unchanged on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req_valid | output | 1 | Read request pending |
| rd_req_ready | input | 1 | Sequencer accepts the request this cycle |
| rd_req_page | output | PAGE_W | Page (row) address of the request |
| rd_req_col | output | COL_W | Column of the marker byte |
| rd_rsp_valid | input | 1 | Response byte present this cycle |
| rd_rsp_data | input | 8 | Returned marker byte |
| scan_done | output | 1 | Walk finished, results final |
| q_blk | input | BLK_W | Block to query |
| q_ready | output | 1 | Query result is meaningful |
| q_invalid | output | 1 | Queried block is invalid |
| valid_count | output | CNT_W | Number of blocks classified valid so far |
| low_valid | output | 1 | Final count is below the rated minimum |

## Verification
The bench builds the block with its default parameters: 512 blocks of 16 pages, marker column 256 and a minimum of 502. This lets it drive the full-size walk and land exactly on the threshold, with 502 valid blocks in one scan and 501 in another. The rated-minimum flag is therefore seen on both sides of its boundary. The same parameters let the walk reach the last block, whose bad marker sits in the second page. Because ready stalls and response latency vary, both the skipped second read and the held-request case occur many times. The bench also applies a reset in the middle of a scan.

// File: rtl/badblk_pkg.sv
package badblk_pkg;

    localparam logic [7:0] ERASED_BYTE = 8'hFF;

    typedef enum logic [1:0] {
        WS_REQ  = 2'd0,
        WS_WAIT = 2'd1,
        WS_DONE = 2'd2
    } walk_state_t;

    typedef struct packed {
        logic fire;   // a block's classification is final this cycle
        logic bad;    // the block is invalid
    } verdict_t;

    function automatic logic marker_bad(input logic [7:0] b);
        return b != ERASED_BYTE;
    endfunction

endpackage

// File: rtl/badblk_walker.sv
module badblk_walker
    import badblk_pkg::*;
#(
    parameter int NUM_BLOCKS    = 512,
    parameter int PAGES_PER_BLK = 16,
    parameter int MARK_COL      = 256,
    parameter int COL_W         = 9,
    parameter int BLK_W         = 9,
    parameter int PAGE_W        = 13
) (
    input  logic              clk,
    input  logic              rst,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [PAGE_W-1:0] req_page,
    output logic [COL_W-1:0]  req_col,
    input  logic              rsp_valid,
    input  logic [7:0]        rsp_data,
    output verdict_t          verdict,
    output logic [BLK_W-1:0]  cur_blk,
    output logic              done
);
    localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(NUM_BLOCKS - 1);

    walk_state_t      state;
    logic [BLK_W-1:0] blk;
    logic             pg;
    logic             byte_bad;
    logic             final_rd;

    assign byte_bad = marker_bad(rsp_data);
    // second page is only needed when the first one looked erased
    assign final_rd = pg | byte_bad;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= WS_REQ;
            blk   <= '0;
            pg    <= 1'b0;
        end else begin
            unique case (state)
                WS_REQ: begin
                    if (req_ready) state <= WS_WAIT;
                end
                WS_WAIT: begin
                    if (rsp_valid) begin
                        if (final_rd) begin
                            pg <= 1'b0;
                            if (blk == LAST_BLK) begin
                                state <= WS_DONE;
                            end else begin
                                blk   <= blk + 1'b1;
                                state <= WS_REQ;
                            end
                        end else begin
                            pg    <= 1'b1;
                            state <= WS_REQ;
                        end
                    end
                end
                WS_DONE: state <= WS_DONE;
                default: state <= WS_REQ;
            endcase
        end
    end

    always_comb begin
        req_valid    = (state == WS_REQ);
        req_page     = PAGE_W'(blk) * PAGE_W'(PAGES_PER_BLK) + PAGE_W'(pg);
        req_col      = COL_W'(MARK_COL);
        verdict.fire = (state == WS_WAIT) && rsp_valid && final_rd;
        verdict.bad  = byte_bad && (blk != '0);
        cur_blk      = blk;
        done         = (state == WS_DONE);
    end

endmodule

// File: rtl/badblk_bitmap.sv
module badblk_bitmap
    import badblk_pkg::*;
#(
    parameter int NUM_BLOCKS = 512,
    parameter int BLK_W      = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  verdict_t         verdict,
    input  logic [BLK_W-1:0] wr_blk,
    input  logic             done,
    input  logic [BLK_W-1:0] q_blk,
    output logic             q_ready,
    output logic             q_invalid
);
    logic [NUM_BLOCKS-1:0] map_q;

    for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                map_q[i] <= 1'b0;
            end else if (verdict.fire && (wr_blk == BLK_W'(i))) begin
                map_q[i] <= verdict.bad;
            end
        end
    end

    assign q_ready   = done;
    assign q_invalid = done & map_q[q_blk];

endmodule

// File: rtl/badblk_tally.sv
module badblk_tally
    import badblk_pkg::*;
#(
    parameter int MIN_VALID = 502,
    parameter int CNT_W     = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  verdict_t         verdict,
    input  logic             done,
    output logic [CNT_W-1:0] count,
    output logic             low
);
    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (verdict.fire && !verdict.bad) begin
            count <= count + 1'b1;
        end
    end

    assign low = done && (count < CNT_W'(MIN_VALID));

endmodule

// File: rtl/badblk_scanner.sv
module badblk_scanner
    import badblk_pkg::*;
#(
    parameter int NUM_BLOCKS    = 512,
    parameter int PAGES_PER_BLK = 16,
    parameter int MARK_COL      = 256,
    parameter int COL_W         = 9,
    parameter int MIN_VALID     = 502,
    localparam int BLK_W        = $clog2(NUM_BLOCKS),
    localparam int PAGE_W       = $clog2(NUM_BLOCKS * PAGES_PER_BLK),
    localparam int CNT_W        = $clog2(NUM_BLOCKS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    output logic              rd_req_valid,
    input  logic              rd_req_ready,
    output logic [PAGE_W-1:0] rd_req_page,
    output logic [COL_W-1:0]  rd_req_col,
    input  logic              rd_rsp_valid,
    input  logic [7:0]        rd_rsp_data,
    output logic              scan_done,
    input  logic [BLK_W-1:0]  q_blk,
    output logic              q_ready,
    output logic              q_invalid,
    output logic [CNT_W-1:0]  valid_count,
    output logic              low_valid
);
    verdict_t         verdict;
    logic [BLK_W-1:0] cur_blk;

    badblk_walker #(
        .NUM_BLOCKS   (NUM_BLOCKS),
        .PAGES_PER_BLK(PAGES_PER_BLK),
        .MARK_COL     (MARK_COL),
        .COL_W        (COL_W),
        .BLK_W        (BLK_W),
        .PAGE_W       (PAGE_W)
    ) u_walker (
        .clk      (clk),
        .rst      (rst),
        .req_valid(rd_req_valid),
        .req_ready(rd_req_ready),
        .req_page (rd_req_page),
        .req_col  (rd_req_col),
        .rsp_valid(rd_rsp_valid),
        .rsp_data (rd_rsp_data),
        .verdict  (verdict),
        .cur_blk  (cur_blk),
        .done     (scan_done)
    );

    badblk_bitmap #(
        .NUM_BLOCKS(NUM_BLOCKS),
        .BLK_W     (BLK_W)
    ) u_bitmap (
        .clk      (clk),
        .rst      (rst),
        .verdict  (verdict),
        .wr_blk   (cur_blk),
        .done     (scan_done),
        .q_blk    (q_blk),
        .q_ready  (q_ready),
        .q_invalid(q_invalid)
    );

    badblk_tally #(
        .MIN_VALID(MIN_VALID),
        .CNT_W    (CNT_W)
    ) u_tally (
        .clk    (clk),
        .rst    (rst),
        .verdict(verdict),
        .done   (scan_done),
        .count  (valid_count),
        .low    (low_valid)
    );

endmodule

// File: rtl/badblk_scanner_chk.sv
module badblk_scanner_chk #(
    parameter int MARK_COL  = 256,
    parameter int COL_W     = 9,
    parameter int PAGE_W    = 13,
    parameter int CNT_W     = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_req_valid,
    input logic              rd_req_ready,
    input logic [PAGE_W-1:0] rd_req_page,
    input logic [COL_W-1:0]  rd_req_col,
    input logic              scan_done,
    input logic              q_ready,
    input logic              q_invalid,
    input logic [CNT_W-1:0]  valid_count,
    input logic              low_valid
);
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_page)); // R9

    AST_REQ_COLUMN: assert property (@(posedge clk) disable iff (rst)
        rd_req_valid |-> rd_req_col == COL_W'(MARK_COL)); // R1

    AST_QUIET_WHEN_DONE: assert property (@(posedge clk) disable iff (rst)
        scan_done |-> !rd_req_valid); // R5

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        scan_done |=> scan_done); // R5

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (valid_count == $past(valid_count)) ||
                 (valid_count == $past(valid_count) + 1'b1)); // R4

    AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        scan_done |=> $stable(valid_count)); // R4

    AST_LOW_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        low_valid |-> scan_done); // R7

    AST_QUERY_GATED: assert property (@(posedge clk) disable iff (rst)
        !scan_done |-> !q_ready && !q_invalid); // R6

endmodule

bind badblk_scanner badblk_scanner_chk #(
    .MARK_COL(MARK_COL),
    .COL_W   (COL_W),
    .PAGE_W  (PAGE_W),
    .CNT_W   (CNT_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .rd_req_valid(rd_req_valid),
    .rd_req_ready(rd_req_ready),
    .rd_req_page (rd_req_page),
    .rd_req_col  (rd_req_col),
    .scan_done   (scan_done),
    .q_ready     (q_ready),
    .q_invalid   (q_invalid),
    .valid_count (valid_count),
    .low_valid   (low_valid)
);

// File: tb/badblk_scanner_bench.sv
`timescale 1ns/1ps
module badblk_scanner_bench;
    localparam int NB   = 512;
    localparam int PPB  = 16;
    localparam int MCOL = 256;
    localparam int MINV = 502;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_req_valid;
    logic        rd_req_ready = 1'b0;
    logic [12:0] rd_req_page;
    logic [8:0]  rd_req_col;
    logic        rd_rsp_valid = 1'b0;
    logic [7:0]  rd_rsp_data = 8'h00;
    logic        scan_done;
    logic [8:0]  q_blk = '0;
    logic        q_ready;
    logic        q_invalid;
    logic [9:0]  valid_count;
    logic        low_valid;

    badblk_scanner u_badblk_scanner (
        .clk(clk), .rst(rst),
        .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
        .rd_req_page(rd_req_page), .rd_req_col(rd_req_col),
        .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
        .scan_done(scan_done), .q_blk(q_blk), .q_ready(q_ready),
        .q_invalid(q_invalid), .valid_count(valid_count), .low_valid(low_valid)
    );

    always #4 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    // reference model state
    int run;
    int eb, ep, ecnt;
    bit edone;
    bit ebad [NB];
    bit pending;
    int cd;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic logic [7:0] marker(input int r, input int b, input int p);
        if (r == 0) begin
            if (b == 0 && p == 0)   return 8'h00;
            if (b == 7 && p == 1)   return 8'hFE;
            if (b == 100 && p == 0) return 8'h00;
            if (b == 300)           return 8'h55;
            if (b == 511 && p == 1) return 8'h7F;
            return 8'hFF;
        end
        if (b == 0 && p == 1) return 8'h3C;
        if (b >= 1 && b <= ((r == 1) ? 10 : 11)) begin
            if (p == 0) return (b % 2 == 1) ? 8'h00 : 8'hFF;
            return 8'hF0;
        end
        return 8'hFF;
    endfunction

    task automatic model_clear();
        eb = 0; ep = 0; ecnt = 0; edone = 1'b0; pending = 1'b0; cd = 0;
        for (int i = 0; i < NB; i++) ebad[i] = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1; rd_req_ready = 1'b0; rd_rsp_valid = 1'b0;
        model_clear();
        repeat (3) begin
            @(negedge clk); cyc++;
            chk(scan_done == 1'b0, "R8 done in reset", scan_done, 0);
            chk(valid_count == 0, "R8 count in reset", valid_count, 0);
            chk(q_ready == 1'b0, "R8 q_ready in reset", q_ready, 0);
        end
        rst = 1'b0;
    endtask

    task automatic step();
        bit go;
        bit bad;
        @(negedge clk); cyc++;
        // outputs versus model
        chk(scan_done == edone, "R5 done", scan_done, edone);
        chk(valid_count == ecnt[9:0], "R4 count", valid_count, ecnt);
        chk(low_valid == (edone && ecnt < MINV), "R7 low flag", low_valid,
            int'(edone && ecnt < MINV));
        if (!edone) chk(!q_ready && !q_invalid, "R6 query gated", {q_ready, q_invalid}, 0);
        if (edone) chk(!rd_req_valid, "R5 no request after done", rd_req_valid, 0);
        // response side
        rd_rsp_valid = 1'b0;
        if (pending) begin
            if (cd == 0) begin
                rd_rsp_data  = marker(run, eb, ep);
                rd_rsp_valid = 1'b1;
                pending      = 1'b0;
                bad = (rd_rsp_data != 8'hFF);
                if (ep == 1 || bad) begin
                    ebad[eb] = bad && (eb != 0);
                    if (!ebad[eb]) ecnt++;
                    if (eb == NB - 1) edone = 1'b1;
                    else begin eb++; ep = 0; end
                end else begin
                    ep = 1;
                end
            end else begin
                cd--;
            end
        end
        // request side
        go = !pending && !rd_rsp_valid && (cyc % 3 != 0);
        if (rd_req_valid && go && !edone) begin
            chk(rd_req_page == 13'(eb * PPB + ep), "R1 page", rd_req_page, eb * PPB + ep);
            chk(rd_req_col == 9'(MCOL), "R1 column", rd_req_col, MCOL);
            pending = 1'b1;
            cd = (eb + ep) % 3;
        end
        rd_req_ready = go;
    endtask

    task automatic check_queries();
        for (int b = 0; b < NB; b++) begin
            q_blk = 9'(b);
            #1;
            chk(q_ready == 1'b1, "R6 q_ready", q_ready, 1);
            if (b == 0) chk(q_invalid == 1'b0, "R3 block zero valid", q_invalid, 0);
            else        chk(q_invalid == ebad[b], "R2 verdict", q_invalid, ebad[b]);
        end
    endtask

    task automatic full_scan();
        while (!edone && cyc < 150000) step();
        repeat (4) step();
        check_queries();
    endtask

    initial begin
        // run 0: scattered markers, block 0 marked in page 0
        run = 0;
        q_blk = 9'd100;
        do_reset();
        full_scan();
        chk(valid_count == 508, "R4 final count run0", valid_count, 508);
        chk(low_valid == 1'b0, "R7 run0 above minimum", low_valid, 0);

        // run 1: exactly at the minimum
        run = 1;
        do_reset();
        full_scan();
        chk(valid_count == 502, "R4 final count run1", valid_count, 502);
        chk(low_valid == 1'b0, "R7 at minimum", low_valid, 0);

        // run 2: reset mid-scan, then one below the minimum
        run = 2;
        do_reset();
        repeat (300) step();
        do_reset();
        full_scan();
        chk(valid_count == 501, "R4 final count run2", valid_count, 501);
        chk(low_valid == 1'b1, "R7 below minimum", low_valid, 1);

        if (cyc >= 150000) chk(1'b0, "watchdog", cyc, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #1600000;
        chk(1'b0, "watchdog expired", cyc, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule